// File: doc/BRIEF.md
# Doorbell-Driven Submission/Completion Ring Controller

This block is the device-side bookkeeping for one command ring and one completion ring, both circular and both kept in host memory with fixed-size slots. The host moves its own side of each ring only by writing a doorbell: the new producer index of the command ring, or the new consumer index of the completion ring. The block keeps the opposite pointer of each ring. It works out the pending work from the gap between the two pointers and presents one fetch request at a time, naming the slot to read.

On the completion side, a processing engine offers results through a valid/ready handshake. The block takes a result only when the host-advertised completion head leaves a free slot. It then issues a slot write request and raises a one-cycle interrupt that carries a fixed vector number. A doorbell value outside the ring is dropped and flagged.

Top module: `qpair_ctrl`

## Requirements
- R1: After reset all four ring indices are zero: both rings report empty, `fetch_valid` is low, `fetch_idx` is 0, `cpl_ready` is high, and `db_err`, `cwr_valid` and `irq` are low.
- R2: A doorbell write with `db_sel`=0 and a value below `DEPTH` sets the command-ring tail. While head and tail differ, `fetch_valid` is high and `fetch_idx` shows the head.
- R3: The command-ring head moves only on a cycle where `fetch_valid` and `fetch_ready` are both high. It moves by one and goes from `DEPTH`-1 back to 0. `fetch_valid` drops once the head reaches the tail.
- R4: A doorbell value greater than or equal to `DEPTH` leaves the selected index unchanged. `db_err` is then high for exactly the one cycle after the write.
- R5: A ring is empty when head equals tail. It is full when head equals (tail+1) mod `DEPTH`, so it holds at most `DEPTH`-1 entries. `sq_empty`, `sq_full`, `cq_empty` and `cq_full` report these states.
- R6: A completion is taken on a cycle with `cpl_valid` and `cpl_ready` both high. In the next cycle `cwr_valid` is high for one cycle and `cwr_idx` shows the completion tail before the take. The tail then moves by one and wraps to 0.
- R7: While the completion ring is full, `cpl_ready` is low and an offered completion waits without loss. A doorbell with `db_sel`=1 moves the completion head and frees room, and the waiting completion is then taken.
- R8: Each completion taken gives a one-cycle `irq` pulse, in the same cycle as its `cwr_valid`, with `irq_vec` equal to `IRQ_VEC`. If `irq_mask` is high on the take cycle, the pulse is suppressed, but the write request and the tail update still happen.
- R9: `DEPTH` is at least 2. It is at most 4096 when `ADMIN` is 1 and at most 65536 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | Doorbell target: 0 command tail, 1 completion head |
| db_val | input | DB_W | Doorbell index value |
| db_err | output | 1 | One-cycle pulse after an out-of-range doorbell |
| fetch_valid | output | 1 | Command slot pending for fetch |
| fetch_ready | input | 1 | Fetch accepted this cycle |
| fetch_idx | output | PTR_W | Slot index to fetch |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion ring has room |
| irq_mask | input | 1 | Suppress the interrupt pulse |
| cwr_valid | output | 1 | Completion slot write request |
| cwr_idx | output | PTR_W | Completion slot to write |
| irq | output | 1 | Interrupt pulse |
| irq_vec | output | VEC_W | Interrupt vector number |
| sq_empty | output | 1 | Command ring empty |
| sq_full | output | 1 | Command ring full |
| cq_empty | output | 1 | Completion ring empty |
| cq_full | output | 1 | Completion ring full |

## Verification
The bench drives the command tail to the full position, past the ring end and back to the head. A design with an off-by-one full test would report full one entry early or late. A design that stores bad values would move the tail and raise `fetch_valid` on an empty ring. It drains fetches across the wrap point, which catches a head that runs past `DEPTH`-1. It fills the completion ring while a completion is offered. A design that posts anyway would overwrite a slot the host still owns and emit a write request with a wrong index. The last tests post with the mask set: a design that ties the mask to the pointers would lose the write request, and one that ignores the mask would pulse `irq`.

// File: rtl/qp_pkg.sv
package qp_pkg;
    typedef enum logic {
        DB_SQ_TAIL = 1'b0,
        DB_CQ_HEAD = 1'b1
    } db_target_e;

    localparam int unsigned ADMIN_MAX_DEPTH = 4096;
    localparam int unsigned IO_MAX_DEPTH    = 65536;
endpackage

// File: rtl/qp_sq_ring.sv
module qp_sq_ring #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DB_W  = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_hit,
    input  logic [DB_W-1:0]  db_val,
    input  logic             fetch_ready,
    output logic             fetch_valid,
    output logic [PTR_W-1:0] fetch_idx,
    output logic             empty,
    output logic             full,
    output logic             err
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             err;
    } sq_state_t;

    sq_state_t st_d, st_q;
    logic             in_range;
    logic             take;
    logic [PTR_W-1:0] tail_inc;

    always_comb begin
        in_range = 32'(db_val) < DEPTH;
        tail_inc = (st_q.tail == LAST) ? '0 : st_q.tail + 1'b1;
        take     = fetch_valid && fetch_ready;
        st_d     = st_q;
        st_d.err = 1'b0;
        if (db_hit) begin
            if (in_range) st_d.tail = db_val[PTR_W-1:0];
            else          st_d.err  = 1'b1;
        end
        if (take) st_d.head = (st_q.head == LAST) ? '0 : st_q.head + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_valid = st_q.head != st_q.tail;
    assign fetch_idx   = st_q.head;
    assign empty       = st_q.head == st_q.tail;
    assign full        = st_q.head == tail_inc;
    assign err         = st_q.err;

    assert_head_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(fetch_idx));
    assert_bad_db_keeps_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_hit && !in_range && !take) |=> ($stable(empty) && $stable(full)));
    assert_err_after_db_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(db_hit));
endmodule

// File: rtl/qp_cq_ring.sv
module qp_cq_ring #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DB_W  = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_hit,
    input  logic [DB_W-1:0]  db_val,
    input  logic             cpl_valid,
    input  logic             irq_mask,
    output logic             cpl_ready,
    output logic             wr_valid,
    output logic [PTR_W-1:0] wr_idx,
    output logic             irq,
    output logic             empty,
    output logic             full,
    output logic             err
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             err;
        logic             wr_valid;
        logic [PTR_W-1:0] wr_idx;
        logic             irq;
    } cq_state_t;

    cq_state_t st_d, st_q;
    logic             in_range;
    logic             take;
    logic [PTR_W-1:0] tail_inc;

    always_comb begin
        in_range      = 32'(db_val) < DEPTH;
        tail_inc      = (st_q.tail == LAST) ? '0 : st_q.tail + 1'b1;
        take          = cpl_valid && cpl_ready;
        st_d          = st_q;
        st_d.err      = 1'b0;
        st_d.wr_valid = 1'b0;
        st_d.irq      = 1'b0;
        if (db_hit) begin
            if (in_range) st_d.head = db_val[PTR_W-1:0];
            else          st_d.err  = 1'b1;
        end
        if (take) begin
            st_d.tail     = tail_inc;
            st_d.wr_valid = 1'b1;
            st_d.wr_idx   = st_q.tail;
            st_d.irq      = !irq_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full      = st_q.head == tail_inc;
    assign empty     = st_q.head == st_q.tail;
    assign cpl_ready = !full;
    assign wr_valid  = st_q.wr_valid;
    assign wr_idx    = st_q.wr_idx;
    assign irq       = st_q.irq;
    assign err       = st_q.err;

    assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> !wr_valid);
    assert_irq_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wr_valid);
    assert_write_follows_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(cpl_valid));
    assert_err_after_db_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(db_hit));
endmodule

// File: rtl/qpair_ctrl.sv
module qpair_ctrl #(
    parameter int unsigned DEPTH   = 16,
    parameter bit          ADMIN   = 1'b0,
    parameter int unsigned DB_W    = 16,
    parameter int unsigned VEC_W   = 11,
    parameter int unsigned IRQ_VEC = 0,
    parameter int unsigned PTR_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_wr,
    input  logic             db_sel,
    input  logic [DB_W-1:0]  db_val,
    output logic             db_err,
    output logic             fetch_valid,
    input  logic             fetch_ready,
    output logic [PTR_W-1:0] fetch_idx,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic             irq_mask,
    output logic             cwr_valid,
    output logic [PTR_W-1:0] cwr_idx,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec,
    output logic             sq_empty,
    output logic             sq_full,
    output logic             cq_empty,
    output logic             cq_full
);
    import qp_pkg::*;

    localparam int unsigned CAP = ADMIN ? ADMIN_MAX_DEPTH : IO_MAX_DEPTH;

    // R9: ring size limits checked when the block is elaborated
    if (DEPTH < 2 || DEPTH > CAP) begin : g_bad_depth
        $error("qpair_ctrl: DEPTH out of the allowed range");
    end

    db_target_e target;
    logic       sq_hit, cq_hit, sq_err, cq_err;

    assign target = db_target_e'(db_sel);
    assign sq_hit = db_wr && (target == DB_SQ_TAIL);
    assign cq_hit = db_wr && (target == DB_CQ_HEAD);

    qp_sq_ring #(.DEPTH(DEPTH), .DB_W(DB_W), .PTR_W(PTR_W)) u_sq (
        .clk        (clk),
        .rst_n      (rst_n),
        .db_hit     (sq_hit),
        .db_val     (db_val),
        .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid),
        .fetch_idx  (fetch_idx),
        .empty      (sq_empty),
        .full       (sq_full),
        .err        (sq_err)
    );

    qp_cq_ring #(.DEPTH(DEPTH), .DB_W(DB_W), .PTR_W(PTR_W)) u_cq (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_hit   (cq_hit),
        .db_val   (db_val),
        .cpl_valid(cpl_valid),
        .irq_mask (irq_mask),
        .cpl_ready(cpl_ready),
        .wr_valid (cwr_valid),
        .wr_idx   (cwr_idx),
        .irq      (irq),
        .empty    (cq_empty),
        .full     (cq_full),
        .err      (cq_err)
    );

    assign db_err  = sq_err || cq_err;
    assign irq_vec = VEC_W'(IRQ_VEC);

    assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sq_empty && sq_full) && !(cq_empty && cq_full));
    assert_err_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_err && !db_wr) |=> !db_err);
endmodule

// File: tb/qpair_ctrl_test.sv
module qpair_ctrl_test;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned PTR_W = 2;
    localparam int unsigned VEC   = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic db_wr, db_sel, fetch_ready, cpl_valid, irq_mask;
    logic [15:0] db_val;
    logic db_err, fetch_valid, cpl_ready, cwr_valid, irq;
    logic sq_empty, sq_full, cq_empty, cq_full;
    logic [PTR_W-1:0] fetch_idx, cwr_idx;
    logic [10:0] irq_vec;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    qpair_ctrl #(.DEPTH(DEPTH), .ADMIN(1'b1), .IRQ_VEC(VEC)) uut (
        .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_sel(db_sel), .db_val(db_val),
        .db_err(db_err), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_idx(fetch_idx), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .irq_mask(irq_mask), .cwr_valid(cwr_valid), .cwr_idx(cwr_idx), .irq(irq),
        .irq_vec(irq_vec), .sq_empty(sq_empty), .sq_full(sq_full),
        .cq_empty(cq_empty), .cq_full(cq_full)
    );

    // {doorbell value[3:0], expected err, expected fetch_valid, expected sq_full}
    localparam logic [6:0] SQ_TBL [0:5] = '{
        {4'd1, 1'b0, 1'b1, 1'b0},
        {4'd3, 1'b0, 1'b1, 1'b1},
        {4'd4, 1'b1, 1'b1, 1'b1},
        {4'd0, 1'b0, 1'b0, 1'b0},
        {4'd9, 1'b1, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a doorbell for one cycle; return at the negedge after the capturing edge
    task automatic ring(input logic sel, input logic [15:0] val);
        @(negedge clk);
        db_wr = 1'b1; db_sel = sel; db_val = val;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic post(input logic mask);
        @(negedge clk);
        cpl_valid = 1'b1; irq_mask = mask;
        @(negedge clk);
        cpl_valid = 1'b0; irq_mask = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; db_wr = 1'b0; db_sel = 1'b0; db_val = '0;
        fetch_ready = 1'b0; cpl_valid = 1'b0; irq_mask = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 fetch_valid", fetch_valid, 0);
        check("R1 fetch_idx", fetch_idx, 0);
        check("R1 sq_empty", sq_empty, 1);
        check("R1 cq_empty", cq_empty, 1);
        check("R1 cpl_ready", cpl_ready, 1);
        check("R1 outputs idle", {db_err, cwr_valid, irq}, 0);

        // R2/R4/R5 tail doorbell table, head parked at 0
        for (int i = 0; i < 6; i++) begin
            ring(1'b0, 16'(SQ_TBL[i][6:3]));
            check("R4 db_err", db_err, int'(SQ_TBL[i][2]));
            check("R2 fetch_valid", fetch_valid, int'(SQ_TBL[i][1]));
            check("R5 sq_full", sq_full, int'(SQ_TBL[i][0]));
            check("R5 sq_empty", sq_empty, int'(!SQ_TBL[i][1]));
            check("R2 fetch_idx", fetch_idx, 0);
        end
        @(negedge clk);
        check("R4 err lasts one cycle", db_err, 0);

        // R3 drain two entries (tail 2)
        fetch_ready = 1'b1;
        @(negedge clk);
        check("R3 head after one fetch", fetch_idx, 1);
        @(negedge clk);
        fetch_ready = 1'b0;
        check("R3 head reaches tail", fetch_idx, 2);
        check("R3 fetch_valid drops", fetch_valid, 0);

        // R3 wrap: tail 0, head 2 -> entries 2,3
        ring(1'b0, 16'd0);
        check("R2 pending over wrap", fetch_valid, 1);
        fetch_ready = 1'b1;
        @(negedge clk);
        check("R3 head 3", fetch_idx, 3);
        @(negedge clk);
        fetch_ready = 1'b0;
        check("R3 head wraps to 0", fetch_idx, 0);
        check("R3 empty after wrap", sq_empty, 1);

        // R6 three posts fill the completion ring
        for (int k = 0; k < 3; k++) begin
            post(1'b0);
            check("R6 cwr_valid", cwr_valid, 1);
            check("R6 cwr_idx", cwr_idx, k);
            check("R8 irq", irq, 1);
            check("R8 irq_vec", irq_vec, VEC);
        end
        @(negedge clk);
        check("R8 irq single cycle", irq, 0);
        check("R5 cq_full", cq_full, 1);
        check("R7 cpl_ready low", cpl_ready, 0);

        // R7 offered completion waits
        cpl_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R7 no write while full", cwr_valid, 0);
            check("R7 no irq while full", irq, 0);
        end
        ring(1'b1, 16'd2);
        check("R7 room after head doorbell", cpl_ready, 1);
        @(negedge clk);
        cpl_valid = 1'b0;
        check("R7 held completion posted", cwr_valid, 1);
        check("R7 held completion slot", cwr_idx, 3);

        // R8 masked post: tail wraps 0 -> 1
        post(1'b1);
        check("R8 mask keeps write", cwr_valid, 1);
        check("R6 tail wrapped slot", cwr_idx, 0);
        check("R8 mask suppresses irq", irq, 0);
        check("R8 mask keeps tail update (full)", cq_full, 1);

        // R4 bad completion head doorbell ignored
        ring(1'b1, 16'd7);
        check("R4 cq db_err", db_err, 1);
        check("R4 cq head unchanged", cq_full, 1);
        ring(1'b1, 16'd1);
        check("R5 cq_empty", cq_empty, 1);
        check("R4 no err on good value", db_err, 0);

        // R9: DEPTH=4 within the admin cap; irq_vec carries the vector
        check("R9 vector at idle", irq_vec, VEC);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule